// File: doc/BRIEF.md
# Supply-Monitor Reset Source Controller

This controller decides when a supply-voltage monitor may pull the chip into reset, and it produces the system reset itself. A power-on input holds the chip in reset, and a delay counter keeps the reset asserted for a fixed number of cycles after that input drops. Once running, the chip can also be reset by three other causes:

- a power-fail event from the monitor;
- a software request;
- a flash erase or write attempted while the monitor is switched off.

Each reset is a registered pulse. A one-hot cause register records which event produced the most recent reset.

Software controls the monitor through two register writes: one enables the monitor and one selects it as a reset source. Both settings are held in user registers. Hardware changes them only on a power-on or power-fail reset, which force both back to 1.

While the chip sleeps, power-fail resets are blocked and the monitor reads as off. On wake, the monitor returns to the user's last settings.

A second comparator input drives a supply-OK status bit. When that input reports the supply below the early-warning threshold, the status bit clears and an optional one-cycle interrupt pulse is raised.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is 1, `rst_cause_o` is 3'b001 and `mon_en_o`/`mon_sel_o` are 1. After `por_i` is sampled low, `sys_rst_o` stays 1 for exactly POR_DLY rising edges and is 0 after the POR_DLY-th edge.
- R2: A power-fail event occurs when the supply is below the reset threshold at a clock edge while `mon_en_o` and `mon_sel_o` are both 1 and `sleep_i` is 0. The event sets `sys_rst_o` at that edge and sets `rst_cause_o` to 3'b001. The reset is held while the condition lasts and is released PULSE_LEN edges after the last event edge, with no power-on delay. Enable and select are both forced to 1.
- R3: A software request taken while `sys_rst_o` is 0 produces a PULSE_LEN-cycle reset and sets `rst_cause_o` to 3'b010. It leaves `mon_en_o` and `mon_sel_o` unchanged.
- R4: A flash strobe while `mon_en_o` is 0 and `sys_rst_o` is 0 produces a PULSE_LEN-cycle reset and sets `rst_cause_o` to 3'b100. A flash strobe while `mon_en_o` is 1 causes no reset.
- R5: A select write with data 1 sets the select bit only if the enable bit was already 1 before that edge. An enable write and a select write in the same cycle leave the select bit at 0 when the enable bit was 0.
- R6: Any select write with data 0 clears the select bit.
- R7: From the edge after `sleep_i` rises, `mon_en_o` and `mon_sel_o` read 0. While `sleep_i` is 1, a below-reset-threshold supply never asserts `sys_rst_o`.
- R8: One edge after `sleep_i` falls, `mon_en_o` and `mon_sel_o` again show the values last written by the user.
- R9: `vdd_ok_o` is 0 from the first edge at which `vdd_below_warn_i` is sampled 1, and returns to 1 one edge after that input is sampled 0. If `warn_ie_i` is 1, `warn_irq_o` pulses for exactly one cycle when `vdd_ok_o` falls.
- R10: With `warn_ie_i` at 0, `warn_irq_o` stays 0 when the supply crosses the warning threshold.
- R11: `rst_cause_o` is always one-hot. Software and flash requests arriving while `sys_rst_o` is 1 are ignored: they neither extend the reset nor change the cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on indication, active high; also the block's synchronous reset |
| vdd_below_rst_i | input | 1 | Comparator: supply below the reset threshold |
| vdd_below_warn_i | input | 1 | Comparator: supply below the early-warning threshold |
| sw_rst_req_i | input | 1 | Software reset request |
| sleep_i | input | 1 | Chip in sleep mode |
| flash_strobe_i | input | 1 | Flash erase/write strobe |
| warn_ie_i | input | 1 | Early-warning interrupt enable |
| mon_en_wr_i | input | 1 | Write strobe for the monitor enable bit |
| mon_en_wdata_i | input | 1 | Value written to the enable bit |
| mon_sel_wr_i | input | 1 | Write strobe for the reset-source select bit |
| mon_sel_wdata_i | input | 1 | Value written to the select bit |
| sys_rst_o | output | 1 | System reset, registered, active high |
| rst_cause_o | output | 3 | One-hot reset cause: bit0 power-on/power-fail, bit1 software, bit2 flash error |
| vdd_ok_o | output | 1 | Supply above the warning threshold |
| warn_irq_o | output | 1 | Early-warning interrupt pulse |
| mon_en_o | output | 1 | Monitor enable as currently seen (0 during sleep) |
| mon_sel_o | output | 1 | Monitor reset-source select as currently seen (0 during sleep) |

## Verification
The reset sequencer is driven with each cause on its own and with causes that overlap:
- Timing the release after power-on against the release after a power-fail shows whether the long delay is applied only where it belongs.
- A power-fail held over several cycles shows whether the pulse is retriggered.
- A software request issued during a flash-error reset shows whether requests arriving during a reset are ignored.

The monitor configuration is probed in several ways:
- Writing enable and select in different orders, including both in one cycle, separates correct select gating from a plain register.
- Power-fail stimulus with the monitor enabled but not selected, and again during sleep, shows whether both blocking conditions are honoured.
- Waking from sleep shows whether the user's settings come back.

The warning path is exercised with the interrupt enabled and disabled, which separates the status bit from the interrupt pulse.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    localparam int CAUSE_W = 3;

    typedef enum logic [1:0] {
        CAUSE_PWR   = 2'd0,
        CAUSE_SW    = 2'd1,
        CAUSE_FLASH = 2'd2
    } cause_e;

    function automatic logic [CAUSE_W-1:0] cause_vec(input cause_e c);
        return CAUSE_W'(1) << c;
    endfunction

endpackage

// File: rtl/supmon_cfg_regs.sv
module supmon_cfg_regs (
    input  logic clk,
    input  logic por_i,
    input  logic sleep_i,
    input  logic pf_set_i,
    input  logic en_wr_i,
    input  logic en_wdata_i,
    input  logic sel_wr_i,
    input  logic sel_wdata_i,
    output logic en_o,
    output logic sel_o
);

    typedef struct packed {
        logic usr_en;
        logic usr_sel;
        logic slp;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d     = cfg_q;
        cfg_d.slp = sleep_i;
        if (pf_set_i) begin
            cfg_d.usr_en  = 1'b1;
            cfg_d.usr_sel = 1'b1;
        end else begin
            if (en_wr_i) begin
                cfg_d.usr_en = en_wdata_i;
            end
            if (sel_wr_i) begin
                // selection only takes when the monitor was already on
                cfg_d.usr_sel = sel_wdata_i & cfg_q.usr_en;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            cfg_q <= '{usr_en: 1'b1, usr_sel: 1'b1, slp: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o  = cfg_q.usr_en  & ~cfg_q.slp;
    assign sel_o = cfg_q.usr_sel & ~cfg_q.slp;

    assert_sel_needs_en_R5: assert property (@(posedge clk) disable iff (por_i)
        (sel_wr_i && !cfg_q.usr_en && !pf_set_i) |=> !cfg_q.usr_sel);

    assert_sel_clear_R6: assert property (@(posedge clk) disable iff (por_i)
        (sel_wr_i && !sel_wdata_i && !pf_set_i) |=> !cfg_q.usr_sel);

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (por_i)
        (!pf_set_i && !en_wr_i && !sel_wr_i) |=>
        ($stable(cfg_q.usr_en) && $stable(cfg_q.usr_sel)));

    assert_pf_restore_R2: assert property (@(posedge clk) disable iff (por_i)
        pf_set_i |=> (cfg_q.usr_en && cfg_q.usr_sel));

endmodule

// File: rtl/supmon_warn.sv
module supmon_warn (
    input  logic clk,
    input  logic por_i,
    input  logic below_warn_i,
    input  logic irq_en_i,
    output logic vdd_ok_o,
    output logic irq_o
);

    typedef struct packed {
        logic ok;
        logic irq;
    } warn_t;

    warn_t warn_d, warn_q;

    always_comb begin
        warn_d     = warn_q;
        warn_d.ok  = ~below_warn_i;
        warn_d.irq = irq_en_i & warn_q.ok & below_warn_i;
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            warn_q <= '{ok: 1'b1, irq: 1'b0};
        end else begin
            warn_q <= warn_d;
        end
    end

    assign vdd_ok_o = warn_q.ok;
    assign irq_o    = warn_q.irq;

    assert_irq_single_R9: assert property (@(posedge clk) disable iff (por_i)
        irq_o |=> !irq_o);

    assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (por_i)
        irq_o |-> !vdd_ok_o);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (por_i)
        !irq_en_i |=> !irq_o);

endmodule

// File: rtl/supmon_rst_seq.sv
module supmon_rst_seq
    import supmon_pkg::*;
#(
    parameter int POR_DLY   = 8,
    parameter int PULSE_LEN = 3
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               pfr_i,
    input  logic               flash_err_i,
    input  logic               sw_req_i,
    output logic               sys_rst_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam int MAX_CNT = (POR_DLY > PULSE_LEN) ? POR_DLY : PULSE_LEN;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] POR_LOAD = CNT_W'(POR_DLY);
    localparam logic [CNT_W-1:0] PUL_LOAD = CNT_W'(PULSE_LEN);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CAUSE_W-1:0] cause;
        logic               rst;
    } seq_t;

    seq_t seq_d, seq_q;
    logic busy;

    assign busy = (seq_q.cnt != '0);

    always_comb begin
        seq_d = seq_q;
        if (pfr_i) begin
            seq_d.cause = cause_vec(CAUSE_PWR);
            seq_d.cnt   = (seq_q.cnt > PUL_LOAD) ? seq_q.cnt - 1'b1 : PUL_LOAD;
        end else if (busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end else if (flash_err_i) begin
            seq_d.cause = cause_vec(CAUSE_FLASH);
            seq_d.cnt   = PUL_LOAD;
        end else if (sw_req_i) begin
            seq_d.cause = cause_vec(CAUSE_SW);
            seq_d.cnt   = PUL_LOAD;
        end
        seq_d.rst = (seq_d.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (por_i) begin
            seq_q <= '{cnt: POR_LOAD, cause: cause_vec(CAUSE_PWR), rst: 1'b1};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sys_rst_o = seq_q.rst;
    assign cause_o   = seq_q.cause;

    assert_cause_onehot_R11: assert property (@(posedge clk) disable iff (por_i)
        $onehot(cause_o));

    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (por_i)
        (busy && !pfr_i) |=> $stable(cause_o));

    assert_pf_reset_R2: assert property (@(posedge clk) disable iff (por_i)
        pfr_i |=> (sys_rst_o && cause_o == cause_vec(CAUSE_PWR)));

    assert_flash_reset_R4: assert property (@(posedge clk) disable iff (por_i)
        (!busy && !pfr_i && flash_err_i) |=>
        (sys_rst_o && cause_o == cause_vec(CAUSE_FLASH)));

    assert_release_count_R1: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> ($past(seq_q.cnt) == CNT_W'(1)));

endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
    import supmon_pkg::*;
#(
    parameter int POR_DLY   = 8,
    parameter int PULSE_LEN = 3
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               vdd_below_rst_i,
    input  logic               vdd_below_warn_i,
    input  logic               sw_rst_req_i,
    input  logic               sleep_i,
    input  logic               flash_strobe_i,
    input  logic               warn_ie_i,
    input  logic               mon_en_wr_i,
    input  logic               mon_en_wdata_i,
    input  logic               mon_sel_wr_i,
    input  logic               mon_sel_wdata_i,
    output logic               sys_rst_o,
    output logic [CAUSE_W-1:0] rst_cause_o,
    output logic               vdd_ok_o,
    output logic               warn_irq_o,
    output logic               mon_en_o,
    output logic               mon_sel_o
);

    logic pfr_evt;
    logic flash_err;

    assign pfr_evt   = mon_en_o & mon_sel_o & vdd_below_rst_i & ~sleep_i;
    assign flash_err = flash_strobe_i & ~mon_en_o;

    supmon_cfg_regs u_cfg (
        .clk         (clk),
        .por_i       (por_i),
        .sleep_i     (sleep_i),
        .pf_set_i    (pfr_evt),
        .en_wr_i     (mon_en_wr_i),
        .en_wdata_i  (mon_en_wdata_i),
        .sel_wr_i    (mon_sel_wr_i),
        .sel_wdata_i (mon_sel_wdata_i),
        .en_o        (mon_en_o),
        .sel_o       (mon_sel_o)
    );

    supmon_rst_seq #(
        .POR_DLY   (POR_DLY),
        .PULSE_LEN (PULSE_LEN)
    ) u_seq (
        .clk         (clk),
        .por_i       (por_i),
        .pfr_i       (pfr_evt),
        .flash_err_i (flash_err),
        .sw_req_i    (sw_rst_req_i),
        .sys_rst_o   (sys_rst_o),
        .cause_o     (rst_cause_o)
    );

    supmon_warn u_warn (
        .clk          (clk),
        .por_i        (por_i),
        .below_warn_i (vdd_below_warn_i),
        .irq_en_i     (warn_ie_i),
        .vdd_ok_o     (vdd_ok_o),
        .irq_o        (warn_irq_o)
    );

    assert_sleep_blocks_R7: assert property (@(posedge clk) disable iff (por_i)
        (sleep_i && !sys_rst_o && !sw_rst_req_i && !flash_strobe_i) |=> !sys_rst_o);

    assert_enabled_flash_ok_R4: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && mon_en_o && flash_strobe_i && !sw_rst_req_i && !vdd_below_rst_i)
        |=> !sys_rst_o);

endmodule

// File: tb/tb_supmon_rst_ctrl.sv
module tb_supmon_rst_ctrl;

    localparam int POR_DLY   = 8;
    localparam int PULSE_LEN = 3;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       vdd_below_rst_i = 1'b0;
    logic       vdd_below_warn_i = 1'b0;
    logic       sw_rst_req_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       flash_strobe_i = 1'b0;
    logic       warn_ie_i = 1'b0;
    logic       mon_en_wr_i = 1'b0;
    logic       mon_en_wdata_i = 1'b0;
    logic       mon_sel_wr_i = 1'b0;
    logic       mon_sel_wdata_i = 1'b0;
    logic       sys_rst_o;
    logic [2:0] rst_cause_o;
    logic       vdd_ok_o;
    logic       warn_irq_o;
    logic       mon_en_o;
    logic       mon_sel_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    supmon_rst_ctrl #(.POR_DLY(POR_DLY), .PULSE_LEN(PULSE_LEN)) dut (
        .clk(clk), .por_i(por_i), .vdd_below_rst_i(vdd_below_rst_i),
        .vdd_below_warn_i(vdd_below_warn_i), .sw_rst_req_i(sw_rst_req_i),
        .sleep_i(sleep_i), .flash_strobe_i(flash_strobe_i), .warn_ie_i(warn_ie_i),
        .mon_en_wr_i(mon_en_wr_i), .mon_en_wdata_i(mon_en_wdata_i),
        .mon_sel_wr_i(mon_sel_wr_i), .mon_sel_wdata_i(mon_sel_wdata_i),
        .sys_rst_o(sys_rst_o), .rst_cause_o(rst_cause_o), .vdd_ok_o(vdd_ok_o),
        .warn_irq_o(warn_irq_o), .mon_en_o(mon_en_o), .mon_sel_o(mon_sel_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_en(input logic v);
        mon_en_wr_i = 1'b1; mon_en_wdata_i = v;
        step(1);
        mon_en_wr_i = 1'b0;
    endtask

    task automatic wr_sel(input logic v);
        mon_sel_wr_i = 1'b1; mon_sel_wdata_i = v;
        step(1);
        mon_sel_wr_i = 1'b0;
    endtask

    task automatic t_por;
        por_i = 1'b1;
        step(2);
        chk("R1 rst during por", 32'(sys_rst_o), 1);
        chk("R1 cause at por", 32'(rst_cause_o), 3'b001);
        chk("R1 en at por", 32'(mon_en_o), 1);
        chk("R1 sel at por", 32'(mon_sel_o), 1);
        chk("R9 vdd_ok at por", 32'(vdd_ok_o), 1);
        chk("R9 irq at por", 32'(warn_irq_o), 0);
        por_i = 1'b0;
        step(POR_DLY - 1);
        chk("R1 rst held through delay", 32'(sys_rst_o), 1);
        step(1);
        chk("R1 rst released after delay", 32'(sys_rst_o), 0);
    endtask

    task automatic t_sel;
        wr_sel(1'b0);
        chk("R6 sel cleared by 0 write", 32'(mon_sel_o), 0);
        wr_en(1'b0);
        wr_sel(1'b1);
        chk("R5 sel ignored while disabled", 32'(mon_sel_o), 0);
        mon_en_wr_i = 1'b1; mon_en_wdata_i = 1'b1;
        mon_sel_wr_i = 1'b1; mon_sel_wdata_i = 1'b1;
        step(1);
        mon_en_wr_i = 1'b0; mon_sel_wr_i = 1'b0;
        chk("R5 same-cycle en", 32'(mon_en_o), 1);
        chk("R5 same-cycle sel stays 0", 32'(mon_sel_o), 0);
        wr_sel(1'b1);
        chk("R5 sel after enable", 32'(mon_sel_o), 1);
    endtask

    task automatic t_sw;
        wr_en(1'b0);
        wr_sel(1'b0);
        sw_rst_req_i = 1'b1;
        step(1);
        sw_rst_req_i = 1'b0;
        chk("R3 sw reset asserted", 32'(sys_rst_o), 1);
        chk("R3 sw cause", 32'(rst_cause_o), 3'b010);
        step(PULSE_LEN - 1);
        chk("R3 sw pulse held", 32'(sys_rst_o), 1);
        step(1);
        chk("R3 sw pulse released", 32'(sys_rst_o), 0);
        chk("R3 en kept after sw", 32'(mon_en_o), 0);
        chk("R3 sel kept after sw", 32'(mon_sel_o), 0);
        wr_en(1'b1);
        wr_sel(1'b1);
    endtask

    task automatic t_pf;
        wr_sel(1'b0);
        vdd_below_rst_i = 1'b1;
        step(2);
        chk("R2 no pf reset when deselected", 32'(sys_rst_o), 0);
        vdd_below_rst_i = 1'b0;
        wr_sel(1'b1);
        vdd_below_rst_i = 1'b1;
        step(1);
        chk("R2 pf reset asserted", 32'(sys_rst_o), 1);
        chk("R2 pf cause", 32'(rst_cause_o), 3'b001);
        step(4);
        chk("R2 pf held while low", 32'(sys_rst_o), 1);
        vdd_below_rst_i = 1'b0;
        step(PULSE_LEN - 1);
        chk("R2 pf pulse tail", 32'(sys_rst_o), 1);
        step(1);
        chk("R2 pf released without por delay", 32'(sys_rst_o), 0);
        chk("R2 en after pf", 32'(mon_en_o), 1);
        chk("R2 sel after pf", 32'(mon_sel_o), 1);
    endtask

    task automatic t_flash;
        flash_strobe_i = 1'b1;
        step(1);
        flash_strobe_i = 1'b0;
        chk("R4 flash ok when enabled", 32'(sys_rst_o), 0);
        wr_en(1'b0);
        flash_strobe_i = 1'b1;
        step(1);
        flash_strobe_i = 1'b0;
        chk("R4 flash error reset", 32'(sys_rst_o), 1);
        chk("R4 flash cause", 32'(rst_cause_o), 3'b100);
        sw_rst_req_i = 1'b1;
        step(1);
        sw_rst_req_i = 1'b0;
        chk("R11 sw ignored during reset cause", 32'(rst_cause_o), 3'b100);
        step(1);
        chk("R11 reset still on", 32'(sys_rst_o), 1);
        step(1);
        chk("R11 reset not extended", 32'(sys_rst_o), 0);
        chk("R11 cause unchanged", 32'(rst_cause_o), 3'b100);
        wr_en(1'b1);
        wr_sel(1'b1);
    endtask

    task automatic t_sleep;
        sleep_i = 1'b1;
        step(1);
        chk("R7 en hidden in sleep", 32'(mon_en_o), 0);
        chk("R7 sel hidden in sleep", 32'(mon_sel_o), 0);
        vdd_below_rst_i = 1'b1;
        step(3);
        chk("R7 no pf reset in sleep", 32'(sys_rst_o), 0);
        vdd_below_rst_i = 1'b0;
        step(1);
        sleep_i = 1'b0;
        step(1);
        chk("R8 en restored", 32'(mon_en_o), 1);
        chk("R8 sel restored", 32'(mon_sel_o), 1);
        wr_sel(1'b0);
        sleep_i = 1'b1;
        step(2);
        sleep_i = 1'b0;
        step(1);
        chk("R8 en restored 1", 32'(mon_en_o), 1);
        chk("R8 sel restored 0", 32'(mon_sel_o), 0);
    endtask

    task automatic t_warn;
        warn_ie_i = 1'b1;
        vdd_below_warn_i = 1'b1;
        step(1);
        chk("R9 vdd_ok cleared", 32'(vdd_ok_o), 0);
        chk("R9 irq pulse", 32'(warn_irq_o), 1);
        step(1);
        chk("R9 irq single cycle", 32'(warn_irq_o), 0);
        chk("R9 vdd_ok stays low", 32'(vdd_ok_o), 0);
        vdd_below_warn_i = 1'b0;
        step(1);
        chk("R9 vdd_ok back", 32'(vdd_ok_o), 1);
        warn_ie_i = 1'b0;
        vdd_below_warn_i = 1'b1;
        step(1);
        chk("R10 vdd_ok cleared masked", 32'(vdd_ok_o), 0);
        chk("R10 no irq when masked", 32'(warn_irq_o), 0);
        step(1);
        chk("R10 still no irq", 32'(warn_irq_o), 0);
        vdd_below_warn_i = 1'b0;
        step(1);
        chk("R9 no reset from warning", 32'(sys_rst_o), 0);
    endtask

    initial begin
        step(1);
        t_por();
        t_sel();
        t_sw();
        t_pf();
        t_flash();
        t_sleep();
        t_warn();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule